// File: doc/BRIEF.md
# Receiver Output Power and Lock Sequencer

This block decides what the parallel output stage of a multi-lane serial receiver does at any moment. It has three states. While the active-low power-down input is low, the outputs are released to high impedance. After power-up, the outputs are driven but held low while a lock interval is counted in reference-clock periods. After that interval they are released. The reference clock reaches the block as a raw level. The block brings it into a free-running system clock domain and watches it for activity. If no rising reference edge is seen within a programmable number of system cycles, the clock counts as lost. All outputs then go low again and the lock count starts over.

Each lane's data outputs and the clock output have their own force-low controls. In plain mode, an undriven data lane holds only that lane low, and an undriven clock input holds every output low. In balanced mode, both undriven indications are ignored.

Two such blocks can drive one shared output bus, selected by their power-down inputs. The system must leave at least 100 ns between disabling one block and enabling the other.

Top module: `out_lock_seq`

## Requirements
- R1: While `pd_n` is low, `out_en` is 0 from the following cycle and the lock count is held at zero.
- R2: After `pd_n` goes high, `out_en` is 1 and `force_clk` and every `force_lane` bit are 1 until lock completes.
- R3: Lock completes once `LOCK_EDGES` rising reference edges have been counted since the last restart. The outputs are released in the cycle after that edge takes effect, never between reference edges.
- R4: If no rising edge of `ref_in` is seen for `idle_limit` system cycles, because the clock has stopped or runs too slowly, all outputs are forced low.
- R5: A clock-loss event resets the lock count to zero. After the clock returns, release needs a full `LOCK_EDGES` count again.
- R6: In plain mode (`balanced` = 0), `lane_open[i]` = 1 forces only `force_lane[i]` to 1. The other lanes stay released.
- R7: In plain mode, `clk_open` = 1 forces `force_clk` and all `force_lane` bits to 1.
- R8: In balanced mode (`balanced` = 1), `lane_open` and `clk_open` have no effect on the outputs.
- R9: A low pulse on `pd_n` in the middle of a lock interval restarts the count from zero on the next rising edge of `pd_n`.
- R10: During reset, `out_en` is 0 and all force outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down (1 = enabled) |
| ref_in | input | 1 | Raw reference clock level, sampled by the block |
| idle_limit | input | IDLE_W | System cycles without a reference edge that mean clock loss |
| balanced | input | 1 | Mode select: 0 plain, 1 balanced |
| lane_open | input | LANES | Per-lane undriven indication |
| clk_open | input | 1 | Reference input undriven indication |
| out_en | output | 1 | 1 drives the outputs, 0 leaves them high impedance |
| force_clk | output | 1 | Forces the clock output low |
| force_lane | output | LANES | Forces each lane's data outputs low |

## Verification
The bench builds the block with three lanes, a lock interval of 12 reference edges and a 6-bit idle limit set to 20 cycles. These values make a full lock take about 72 system cycles, so one run can include several relocks. A reference half period of 15 system cycles stays under the idle limit per half but still exceeds it over a full period. This exercises the slow-clock case as well as a fully stopped clock. A power-down pulse in the middle of a lock and a relock after clock loss both fall within the short lock interval.

// File: rtl/ols_pkg.sv
package ols_pkg;
   typedef enum logic {
      MODE_PLAIN    = 1'b0,
      MODE_BALANCED = 1'b1
   } lane_mode_e;

   function automatic logic failsafe_active(input logic mode_bit, input logic open_bit);
      return (lane_mode_e'(mode_bit) == MODE_PLAIN) && open_bit;
   endfunction
endpackage

// File: rtl/ols_ref_edge.sv
module ols_ref_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic rise
);
   localparam int DEPTH = SYNC_STAGES + 1;
   logic [DEPTH-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[DEPTH-2:0], ref_in};
   end

   assign rise = shreg[DEPTH-2] & ~shreg[DEPTH-1];
endmodule

// File: rtl/ols_activity_mon.sv
module ols_activity_mon #(
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              ref_rise,
   input  logic [IDLE_W-1:0] idle_limit,
   output logic              lost
);
   localparam logic [IDLE_W-1:0] SAT = '1;
   logic [IDLE_W-1:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idle_cnt <= '0;
      else if (!enable || ref_rise) idle_cnt <= '0;
      else if (idle_cnt != SAT)     idle_cnt <= idle_cnt + 1'b1;
   end

   assign lost = (idle_cnt >= idle_limit);
endmodule

// File: rtl/ols_lock_timer.sv
module ols_lock_timer #(
   parameter int LOCK_EDGES = 32800,
   parameter int CW         = $clog2(LOCK_EDGES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          ref_rise,
   output logic [CW-1:0] count,
   output logic          done
);
   localparam logic [CW-1:0] TARGET = CW'(LOCK_EDGES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         count <= '0;
      else if (clear)                     count <= '0;
      else if (ref_rise && count != TARGET) count <= count + 1'b1;
   end

   assign done = (count == TARGET);
endmodule

// File: rtl/out_lock_seq.sv
module out_lock_seq
   import ols_pkg::*;
#(
   parameter int LANES      = 3,
   parameter int LOCK_EDGES = 32800,
   parameter int IDLE_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              ref_in,
   input  logic [IDLE_W-1:0] idle_limit,
   input  logic              balanced,
   input  logic [LANES-1:0]  lane_open,
   input  logic              clk_open,
   output logic              out_en,
   output logic              force_clk,
   output logic [LANES-1:0]  force_lane
);
   localparam int CW = $clog2(LOCK_EDGES + 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LOCK_EDGES < 1) begin : g_bad_lock
      $error("LOCK_EDGES must be at least 1");
   end
   if (IDLE_W < 2) begin : g_bad_idle
      $error("IDLE_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic          ref_edge;
   logic          clk_lost;
   logic          locked;
   logic [CW-1:0] lock_cnt;
   logic          hold_all;

   ols_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (ref_in),
      .rise   (ref_edge)
   );

   ols_activity_mon #(.IDLE_W(IDLE_W)) u_act (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (pd_n),
      .ref_rise   (ref_edge),
      .idle_limit (idle_limit),
      .lost       (clk_lost)
   );

   ols_lock_timer #(.LOCK_EDGES(LOCK_EDGES), .CW(CW)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!pd_n || clk_lost),
      .ref_rise (ref_edge),
      .count    (lock_cnt),
      .done     (locked)
   );

   assign hold_all = !pd_n || !locked || clk_lost || failsafe_active(balanced, clk_open);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en    <= 1'b0;
         force_clk <= 1'b1;
      end else begin
         out_en    <= pd_n;
         force_clk <= hold_all;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) force_lane[i] <= 1'b1;
         else        force_lane[i] <= hold_all || failsafe_active(balanced, lane_open[i]);
      end
   end
endmodule

// File: rtl/out_lock_seq_chk.sv
module out_lock_seq_chk #(
   parameter int LANES = 3,
   parameter int CW    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_n,
   input logic             balanced,
   input logic             clk_open,
   input logic             out_en,
   input logic             force_clk,
   input logic [LANES-1:0] force_lane,
   input logic             ref_edge,
   input logic             clk_lost,
   input logic             locked,
   input logic [CW-1:0]    lock_cnt
);
   assert_pd_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> !out_en);

   assert_pd_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> (lock_cnt == '0));

   assert_release_needs_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !force_clk |-> out_en);

   assert_lock_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(ref_edge));

   assert_loss_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_lost |=> force_clk);

   assert_loss_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_lost && pd_n) |=> !locked);

   assert_clk_forces_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_clk |-> (&force_lane));

   assert_open_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!balanced && clk_open && pd_n) |=> force_clk);

   assert_balanced_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (balanced && locked && !clk_lost && pd_n) |=> (!force_clk && (force_lane == '0)));
endmodule

bind out_lock_seq out_lock_seq_chk #(.LANES(LANES), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pd_n       (pd_n),
   .balanced   (balanced),
   .clk_open   (clk_open),
   .out_en     (out_en),
   .force_clk  (force_clk),
   .force_lane (force_lane),
   .ref_edge   (ref_edge),
   .clk_lost   (clk_lost),
   .locked     (locked),
   .lock_cnt   (lock_cnt)
);

// File: tb/out_lock_seq_tb_top.sv
module out_lock_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 3;
   localparam int LOCK_EDGES = 12;
   localparam int IDLE_W     = 6;
   localparam int IDLE_LIM   = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pd_n = 1'b0;
   logic              ref_in = 1'b0;
   logic [IDLE_W-1:0] idle_limit = IDLE_W'(IDLE_LIM);
   logic              balanced = 1'b0;
   logic [LANES-1:0]  lane_open = '0;
   logic              clk_open = 1'b0;
   logic              out_en;
   logic              force_clk;
   logic [LANES-1:0]  force_lane;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R10";
   int    ref_half = 3;
   bit    ref_stop = 1'b0;
   bit    done = 1'b0;

   // reference model state
   int q0 = 0, q1 = 0, q2 = 0;
   int idle_m = 0, lock_m = 0;
   bit m_en = 1'b0, m_fclk = 1'b1;
   bit m_flane [LANES];

   out_lock_seq #(.LANES(LANES), .LOCK_EDGES(LOCK_EDGES), .IDLE_W(IDLE_W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pd_n       (pd_n),
      .ref_in     (ref_in),
      .idle_limit (idle_limit),
      .balanced   (balanced),
      .lane_open  (lane_open),
      .clk_open   (clk_open),
      .out_en     (out_en),
      .force_clk  (force_clk),
      .force_lane (force_lane)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         if (!ref_stop) begin
            repeat (ref_half - 1) @(negedge clk);
            ref_in = ~ref_in;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         q0 = 0; q1 = 0; q2 = 0; idle_m = 0; lock_m = 0;
         m_en = 1'b0; m_fclk = 1'b1;
         for (int i = 0; i < LANES; i++) m_flane[i] = 1'b1;
      end else begin
         bit seen, gone, have_lock, all_low;
         seen      = (q1 == 1) && (q2 == 0);
         gone      = idle_m >= IDLE_LIM;
         have_lock = lock_m == LOCK_EDGES;
         all_low   = !pd_n || !have_lock || gone || (!balanced && clk_open);
         m_en   = pd_n;
         m_fclk = all_low;
         for (int i = 0; i < LANES; i++) m_flane[i] = all_low || (!balanced && lane_open[i]);
         if (!pd_n || seen) idle_m = 0;
         else if (idle_m < (1 << IDLE_W) - 1) idle_m++;
         if (!pd_n || gone) lock_m = 0;
         else if (seen && lock_m < LOCK_EDGES) lock_m++;
         q2 = q1; q1 = q0; q0 = int'(ref_in);
      end
   end

   task automatic check_bit(string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check_bit("out_en", out_en, m_en);
         check_bit("force_clk", force_clk, m_fclk);
         for (int i = 0; i < LANES; i++) check_bit("force_lane", force_lane[i], m_flane[i]);
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      run(1);
      // R10: reset values
      cur_req = "R10";
      run(3);
      check_bit("reset out_en", out_en, 1'b0);
      check_bit("reset force_clk", force_clk, 1'b1);
      check_bit("reset lane", &force_lane, 1'b1);
      rst_n = 1'b1;

      // R1: powered down with a running clock
      cur_req = "R1";
      run(40);
      check_bit("pd out_en", out_en, 1'b0);

      // R2 then R3: power up and lock
      pd_n = 1'b1;
      cur_req = "R2";
      run(30);
      check_bit("locking out_en", out_en, 1'b1);
      check_bit("locking force_clk", force_clk, 1'b1);
      cur_req = "R3";
      run(70);
      check_bit("released force_clk", force_clk, 1'b0);
      check_bit("released lanes", |force_lane, 1'b0);

      // R6: one undriven lane in plain mode
      cur_req = "R6";
      lane_open = 3'b010;
      run(4);
      check_bit("open lane forced", force_lane[1], 1'b1);
      check_bit("other lane free", force_lane[0], 1'b0);
      check_bit("clock free", force_clk, 1'b0);
      lane_open = '0;
      run(3);

      // R7: undriven clock input in plain mode
      cur_req = "R7";
      clk_open = 1'b1;
      run(4);
      check_bit("clk_open forces all", &force_lane & force_clk, 1'b1);
      clk_open = 1'b0;
      run(3);
      check_bit("clk_open cleared", force_clk, 1'b0);

      // R8: balanced mode ignores the undriven indications
      cur_req = "R8";
      balanced = 1'b1;
      lane_open = '1;
      clk_open = 1'b1;
      run(6);
      check_bit("balanced clk free", force_clk, 1'b0);
      check_bit("balanced lanes free", |force_lane, 1'b0);
      balanced = 1'b0;
      lane_open = '0;
      clk_open = 1'b0;
      run(3);

      // R4: slow reference clock
      cur_req = "R4";
      ref_half = 15;
      run(70);
      check_bit("slow clock forced", force_clk, 1'b1);
      // R5: relock needs the full count again
      cur_req = "R5";
      ref_half = 3;
      run(40);
      check_bit("relock not early", force_clk, 1'b1);
      run(80);
      check_bit("relock done", force_clk, 1'b0);

      // R4: stopped reference clock
      cur_req = "R4";
      ref_stop = 1'b1;
      run(40);
      check_bit("stopped clock forced", force_clk, 1'b1);
      cur_req = "R5";
      ref_stop = 1'b0;
      run(110);
      check_bit("relock after stop", force_clk, 1'b0);

      // R9: power-down pulse mid lock restarts the count
      cur_req = "R9";
      pd_n = 1'b0;
      run(5);
      pd_n = 1'b1;
      run(45);
      pd_n = 1'b0;
      run(5);
      check_bit("pulse hiz", out_en, 1'b0);
      pd_n = 1'b1;
      run(45);
      check_bit("restart not early", force_clk, 1'b1);
      run(60);
      check_bit("restart done", force_clk, 1'b0);

      run(2);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end
endmodule